// File: doc/BRIEF.md
# Colour Palette Loader with Lookup Port

This block holds a 256-entry colour table, each entry built from an 8-bit red, green and blue component. A host fills the table through a 16-byte register window of 32-bit words. One register chooses the entry to load. The other register takes one colour component per write, always in red, green, blue order. After the third component the entry number advances by itself, so the host can stream a whole palette after a single address write.

A display pipeline reads the table through a separate port. It presents an 8-bit index and gets back the packed 24-bit colour one clock later. The host window has no readback path, and host reads return zero. After reset the table is all black except the last entry, which is white.

Top module: `pal_lut_regs`

## Requirements
- R1: After reset, every entry reads 24'h000000 on the lookup port, except entry 255, which reads 24'hFFFFFF.
- R2: `lut_rgb_o` shows the entry addressed by `lut_idx_i` at a rising clock edge from that edge onward. The colour is packed as {red[23:16], green[15:8], blue[7:0]}. If a host write changes the same entry at that same edge, the output shows the contents before the write.
- R3: A host write to byte offset 0 (`host_addr_i` = 4'h0) loads the entry index from `host_wdata_i[31:24]`. It also returns the component sequence to red.
- R4: Successive host writes to byte offset 4 (`host_addr_i` = 4'h4) store `host_wdata_i[31:24]` into the red, then the green, then the blue component of the current entry. Bits [23:0] of the write data have no effect.
- R5: The blue write increments the entry index by one, wrapping from 255 to 0. The next data write is red again.
- R6: Host writes to offsets 4'h8 and 4'hC, host writes to any offset that is not a multiple of four, and all host reads change neither the table, the index nor the component sequence.
- R7: `host_rdata_o` is always zero.
- R8: An address write after only part of an entry has been loaded abandons that partial sequence. Components already written stay in the table, and the next data write goes to red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access valid this cycle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 4 | Byte offset within the window |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (always zero) |
| lut_idx_i | input | 8 | Lookup index from the display pipeline |
| lut_rgb_o | output | 24 | Colour of the looked-up entry, one cycle later |

## Verification
Two functions can fall in the same cycle: a lookup and a host component write that land on the same entry at the same clock edge. The bench provokes this by presenting the lookup of an entry in the very cycle that its blue write is issued. It expects the old red/green/black value first. It then repeats the lookup one cycle later and expects the completed colour. Ignored offsets and reads are judged by the colour that the next legal data write produces, and by which component that write lands in.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;
endpackage

// File: rtl/pal_reg_decode.sv
module pal_reg_decode #(
  parameter int AW       = 4,
  parameter int OFS_ADDR = 0,
  parameter int OFS_DATA = 4
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          addr_wr_o,
  output logic          data_wr_o
);
  localparam logic [AW-1:0] A_IDX = AW'(OFS_ADDR);
  localparam logic [AW-1:0] A_DAT = AW'(OFS_DATA);

  logic wr;
  assign wr        = req_i & we_i;
  assign addr_wr_o = wr & (addr_i == A_IDX);
  assign data_wr_o = wr & (addr_i == A_DAT);
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_wr_i,
  input  logic          data_wr_i,
  input  logic [IW-1:0] wbyte_i,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output comp_e         wr_comp_o
);
  logic [IW-1:0] idx_q;
  comp_e         comp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      comp_q <= COMP_R;
    end else if (addr_wr_i) begin
      idx_q  <= wbyte_i;
      comp_q <= COMP_R;
    end else if (data_wr_i) begin
      unique case (comp_q)
        COMP_R:  comp_q <= COMP_G;
        COMP_G:  comp_q <= COMP_B;
        default: begin
          comp_q <= COMP_R;
          idx_q  <= idx_q + 1'b1;  // wraps at 2**IW
        end
      endcase
    end
  end

  assign wr_en_o   = data_wr_i;
  assign wr_idx_o  = idx_q;
  assign wr_comp_o = comp_q;
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IW = 8,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  comp_e         wr_comp_i,
  input  logic [CW-1:0] wr_val_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [3*CW-1:0] rd_rgb_o
);
  localparam int N = 1 << IW;

  logic [3*CW-1:0] ent_q [N];
  logic [3*CW-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) ent_q[i] <= (i == N - 1) ? '1 : '0;
    end else if (wr_en_i) begin
      unique case (wr_comp_i)
        COMP_R:  ent_q[wr_idx_i][3*CW-1:2*CW] <= wr_val_i;
        COMP_G:  ent_q[wr_idx_i][2*CW-1:CW]   <= wr_val_i;
        default: ent_q[wr_idx_i][CW-1:0]      <= wr_val_i;
      endcase
    end
  end

  // read-before-write on a same-edge collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= ent_q[rd_idx_i];
  end

  assign rd_rgb_o = rd_q;
endmodule

// File: rtl/pal_lut_regs.sv
module pal_lut_regs
  import pal_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int IW = 8,
  parameter int CW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            host_req_i,
  input  logic            host_we_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic [DW-1:0]   host_rdata_o,
  input  logic [IW-1:0]   lut_idx_i,
  output logic [3*CW-1:0] lut_rgb_o
);
  localparam int TOPW = (IW > CW) ? IW : CW;

  logic            addr_wr, data_wr, wr_en;
  logic [IW-1:0]   wr_idx;
  comp_e           wr_comp;
  logic [TOPW-1:0] top_byte;
  logic            unused_w;

  assign top_byte = host_wdata_i[DW-1 -: TOPW];
  assign unused_w = ^host_wdata_i[DW-TOPW-1:0];

  pal_reg_decode #(.AW(AW)) u_dec (
    .req_i     (host_req_i),
    .we_i      (host_we_i),
    .addr_i    (host_addr_i),
    .addr_wr_o (addr_wr),
    .data_wr_o (data_wr)
  );

  pal_seq #(.IW(IW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_wr_i (addr_wr),
    .data_wr_i (data_wr),
    .wbyte_i   (top_byte[TOPW-1 -: IW]),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_comp_o (wr_comp)
  );

  pal_store #(.IW(IW), .CW(CW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_comp_i (wr_comp),
    .wr_val_i  (top_byte[TOPW-1 -: CW]),
    .rd_idx_i  (lut_idx_i),
    .rd_rgb_o  (lut_rgb_o)
  );

  assign host_rdata_o = '0;
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int IW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_req_i,
  input logic          host_we_i,
  input logic [AW-1:0] host_addr_i,
  input logic [DW-1:0] host_wdata_i,
  input logic [IW-1:0] cur_idx_i,
  input logic [1:0]    cur_comp_i
);
  logic hw_idx, hw_dat;
  assign hw_idx = host_req_i && host_we_i && (host_addr_i == AW'(0));
  assign hw_dat = host_req_i && host_we_i && (host_addr_i == AW'(4));

  // R3
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_idx |=> (cur_idx_i == $past(host_wdata_i[DW-1 -: IW])) && (cur_comp_i == 2'd0));

  // R4
  red_to_green_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_dat && cur_comp_i == 2'd0) |=> (cur_comp_i == 2'd1) && $stable(cur_idx_i));

  // R4
  green_to_blue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_dat && cur_comp_i == 2'd1) |=> (cur_comp_i == 2'd2) && $stable(cur_idx_i));

  // R5
  blue_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_dat && cur_comp_i == 2'd2) |=> (cur_comp_i == 2'd0) && (cur_idx_i == IW'($past(cur_idx_i) + 1'b1)));

  // R6
  ignored_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_idx && !hw_dat) |=> $stable(cur_idx_i) && $stable(cur_comp_i));
endmodule

bind pal_lut_regs pal_lut_chk #(.AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_req_i   (host_req_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .cur_idx_i    (wr_idx),
  .cur_comp_i   (wr_comp)
);

// File: tb/pal_lut_regs_tb.sv
module pal_lut_regs_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_req_i = 1'b0, host_we_i = 1'b0;
  logic [3:0]  host_addr_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic [7:0]  lut_idx_i = '0;
  logic [23:0] lut_rgb_o;

  int n_chk = 0, n_bad = 0;
  logic [23:0] mdl [256];
  logic [7:0]  b_idx = '0;
  int          b_st = 0;
  typedef struct { logic [23:0] rgb; logic [7:0] idx; string tag; } exp_t;
  exp_t exp_q [$];

  always #10 clk = ~clk;

  pal_lut_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_req_i(host_req_i), .host_we_i(host_we_i),
    .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o),
    .lut_idx_i(lut_idx_i), .lut_rgb_o(lut_rgb_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected colour per lookup issued before the edge
  initial forever begin
    @(posedge clk); #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk($sformatf("%s idx %0d", e.tag, e.idx), {8'h0, lut_rgb_o}, {8'h0, e.rgb});
    end
  end

  // one cycle of stimulus; optional lookup pushed before the model updates (R2)
  task automatic cyc(bit req, bit we, logic [3:0] a, logic [31:0] d,
                     bit look = 0, logic [7:0] li = 0, string tag = "");
    @(negedge clk);
    host_req_i = req; host_we_i = we; host_addr_i = a; host_wdata_i = d;
    if (look) begin
      lut_idx_i = li;
      exp_q.push_back('{mdl[li], li, tag});
    end
    if (req && we && a == 4'h0) begin
      b_idx = d[31:24]; b_st = 0;
    end else if (req && we && a == 4'h4) begin
      case (b_st)
        0: mdl[b_idx][23:16] = d[31:24];
        1: mdl[b_idx][15:8]  = d[31:24];
        default: mdl[b_idx][7:0] = d[31:24];
      endcase
      if (b_st == 2) begin b_st = 0; b_idx = b_idx + 8'd1; end
      else b_st++;
    end
    if (req && !we) begin
      #1 chk("R7 rdata", host_rdata_o, 32'h0);
    end
  endtask

  task automatic idle(); cyc(0, 0, 4'h0, 32'h0); endtask
  task automatic look(logic [7:0] i, string tag); cyc(0, 0, 4'h0, 32'h0, 1, i, tag); endtask
  task automatic wa(logic [7:0] i); cyc(1, 1, 4'h0, {i, 24'hA5C3E1}); endtask
  task automatic wd(logic [7:0] v); cyc(1, 1, 4'h4, {v, 24'h5A3C1E}); endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset contents
    for (int i = 0; i < 256; i++) look(i[7:0], "R1 reset");
    // R7 reads at both register offsets
    cyc(1, 0, 4'h0, 32'h0); cyc(1, 0, 4'h4, 32'h0);
    // R3 R4 load entry 10, junk in low bits
    wa(8'd10); wd(8'h11); wd(8'h22); wd(8'h33);
    look(8'd10, "R3 R4 entry");
    // R5 streaming into next entry
    wd(8'h44); wd(8'h55); wd(8'h66);
    look(8'd11, "R5 advance"); look(8'd10, "R4 unchanged");
    // R5 wrap 255 -> 0
    wa(8'd255); wd(8'h01); wd(8'h02); wd(8'h03);
    wd(8'h04); wd(8'h05); wd(8'h06);
    look(8'd255, "R5 last"); look(8'd0, "R5 wrap");
    // R8 abandon partial entry
    wa(8'd20); wd(8'h77); wd(8'h88); wa(8'd20); wd(8'h99);
    look(8'd20, "R8 restart");
    wd(8'hAB); wd(8'hCD);
    look(8'd20, "R8 complete"); look(8'd21, "R8 next");
    // R6 ignored offsets and reads mid-sequence
    wa(8'd30); wd(8'h12);
    cyc(1, 1, 4'h8, 32'h4000_0000); cyc(1, 1, 4'hC, 32'h4100_0000);
    cyc(1, 1, 4'h1, 32'h4200_0000); cyc(1, 1, 4'h5, 32'h4300_0000);
    cyc(1, 0, 4'h4, 32'h4400_0000); cyc(1, 0, 4'h0, 32'h4500_0000);
    wd(8'h34); wd(8'h56);
    look(8'd30, "R6 ignored");
    look(8'd64, "R6 no stray"); look(8'd31, "R6 index");
    // R2 collision: lookup in same cycle as blue write
    wa(8'd40); wd(8'hDE); wd(8'hAD);
    cyc(1, 1, 4'h4, {8'hBE, 24'h0}, 1, 8'd40, "R2 old");
    look(8'd40, "R2 new");
    idle(); idle(); idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule